// File: doc/BRIEF.md
# Embedded Flash Command Controller

This block is the register-side front end of an on-chip flash bank. Software programs a timing value into a mode register. It then issues commands by writing a 32-bit command word that carries a protection key, a page number and an operation code. The controller checks the key and the code. It refuses operations that would touch write-protected regions, and holds a busy window whose length comes from the mode register. When the window closes, it applies the result to its non-volatile state bits and pulses a write or erase strobe toward the cell array.

The non-volatile state is made up of three parts: one lock bit per lock region, a small set of general-purpose bits, and a security bit. All of it is visible in the status register together with ready, end-of-lock and two sticky error flags. Lock commands address a page, but each one acts on the whole region that holds that page. The register bus is a single-cycle strobe interface. Read data is combinational from the address, and a status read clears the sticky flags on the following clock edge.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, status reads 0x00000001: ready at bit 0, with all flags, lock bits, general-purpose bits and the security bit clear. The mode register reads 0.
- R2: The command word is the key in bits [31:24], the page in [17:8] and the code in [7:0]. A write whose key is not 0x5A sets the bad-command flag (status bit 3), starts nothing and leaves ready high.
- R3: A code other than 0x01, 0x02, 0x03, 0x04, 0x08, 0x0B, 0x0D or 0x0F sets the bad-command flag and starts nothing.
- R4: An accepted operation holds ready low for max(1, F) status samples, where F is mode bits [23:16].
- R5: A command write that arrives while ready is low is ignored entirely.
- R6: Code 0x02 sets and code 0x04 clears the lock bit of region page/PAGES_PER_REGION. It is shown at status bit 16+region.
- R7: The set-lock and clear-lock codes raise the end-of-lock flag (status bit 1) when they complete. No other code raises it.
- R8: Code 0x01 (write page) and code 0x03 (write page, then lock its region) aimed at a locked region set the lock-error flag (status bit 2) and do nothing. Otherwise a one-cycle array_wr_o pulse carries the page at completion, and code 0x03 also sets the region's lock bit.
- R9: Erase-all (0x08) with any lock bit set and the security bit clear sets the lock-error flag and does nothing. Otherwise it pulses array_erase_o and clears all lock bits and the security bit.
- R10: Code 0x0B sets and code 0x0D clears general-purpose bit `page`, shown at status bits [15:8]. A page at or above NUM_GP is a bad command.
- R11: Code 0x0F sets the security bit (status bit 4). Only erase-all clears it.
- R12: The bad-command, lock-error and end-of-lock flags are sticky and are cleared by a status read.
- R13: Mode register reads return only the cycle field [23:16] and the wait-state bit [8]. Registers: mode 0x0, command 0x4, status 0x8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 4 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data (combinational) |
| array_wr_o | output | 1 | Page program strobe to the array |
| array_erase_o | output | 1 | Full erase strobe to the array |
| array_page_o | output | 10 | Page number for the strobes |

## Verification
Some properties are checked on every cycle. The two strobes are mutually exclusive single-cycle pulses. Lock bits change only at an operation's completion. The security bit falls only together with an erase pulse, and an erase leaves locks and security clear. A status read with no completion pending leaves every sticky flag clear.

Other properties can only be shown by the bench's scenarios. These are the busy length for each cycle-field value, the exact region that a page maps to, rejection by key and by code, the ignoring of commands during busy, and the refusal of locked writes and erases. The bench covers them with sweeps over every code byte, every region and a range of timing values.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [7:0] CMD_KEY = 8'h5A;

  localparam logic [7:0] OP_WR_PAGE   = 8'h01;
  localparam logic [7:0] OP_LOCK      = 8'h02;
  localparam logic [7:0] OP_WR_LOCK   = 8'h03;
  localparam logic [7:0] OP_UNLOCK    = 8'h04;
  localparam logic [7:0] OP_ERASE_ALL = 8'h08;
  localparam logic [7:0] OP_GP_SET    = 8'h0B;
  localparam logic [7:0] OP_GP_CLR    = 8'h0D;
  localparam logic [7:0] OP_SEC_SET   = 8'h0F;

  localparam logic [3:0] OFS_MODE = 4'h0;
  localparam logic [3:0] OFS_CMD  = 4'h4;
  localparam logic [3:0] OFS_STAT = 4'h8;

  typedef struct packed {
    logic lock_err;
    logic bad_cmd;
    logic eol;
  } flags_t;
endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int NUM_REGIONS      = 16,
  parameter int PAGES_PER_REGION = 64,
  parameter int NUM_GP           = 3,
  parameter int PAGE_W           = 10,
  localparam int RGN_W           = $clog2(NUM_REGIONS)
) (
  input  logic [31:0]            word_i,
  input  logic [NUM_REGIONS-1:0] lock_i,
  input  logic                   sec_i,
  output logic                   legal_o,
  output logic                   lock_err_o,
  output logic [7:0]             op_o,
  output logic [PAGE_W-1:0]      page_o,
  output logic [RGN_W-1:0]       region_o
);
  logic [PAGE_W-1:0] rgn_full;
  logic known, uses_rgn, uses_gp, rgn_ok, gp_ok, key_ok;

  assign op_o     = word_i[7:0];
  assign page_o   = word_i[8 +: PAGE_W];
  assign key_ok   = word_i[31:24] == CMD_KEY;
  assign rgn_full = page_o / PAGE_W'(PAGES_PER_REGION);
  assign region_o = rgn_full[RGN_W-1:0];
  assign rgn_ok   = int'(rgn_full) < NUM_REGIONS;
  assign gp_ok    = int'(page_o) < NUM_GP;

  logic unused_bits;
  assign unused_bits = ^word_i[23:8+PAGE_W];

  always_comb begin
    known    = 1'b1;
    uses_rgn = 1'b0;
    uses_gp  = 1'b0;
    case (op_o)
      OP_WR_PAGE, OP_WR_LOCK, OP_LOCK, OP_UNLOCK: uses_rgn = 1'b1;
      OP_GP_SET, OP_GP_CLR:                       uses_gp  = 1'b1;
      OP_ERASE_ALL, OP_SEC_SET:                   ;
      default:                                    known    = 1'b0;
    endcase
  end

  assign legal_o = key_ok && known && (!uses_rgn || rgn_ok) && (!uses_gp || gp_ok);

  // a locked target region blocks a write; any lock blocks erase unless secured
  assign lock_err_o = ((op_o == OP_WR_PAGE || op_o == OP_WR_LOCK) && lock_i[region_o])
                    || (op_o == OP_ERASE_ALL && (|lock_i) && !sec_i);
endmodule

// File: rtl/flash_cmd_timer.sv
module flash_cmd_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] cycles_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = busy_o && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      cnt_q  <= (cycles_i == '0) ? '0 : cycles_i - 1'b1;
    end else if (done_o) begin
      busy_o <= 1'b0;
    end else if (busy_o) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/flash_cmd_nvstate.sv
module flash_cmd_nvstate
  import flash_cmd_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int NUM_GP      = 3,
  localparam int RGN_W      = $clog2(NUM_REGIONS),
  localparam int GP_W       = (NUM_GP > 1) ? $clog2(NUM_GP) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   apply_i,
  input  logic [7:0]             op_i,
  input  logic [RGN_W-1:0]       region_i,
  input  logic [GP_W-1:0]        gp_idx_i,
  output logic [NUM_REGIONS-1:0] lock_o,
  output logic [NUM_GP-1:0]      gp_o,
  output logic                   sec_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_o <= '0;
      gp_o   <= '0;
      sec_o  <= 1'b0;
    end else if (apply_i) begin
      case (op_i)
        OP_LOCK, OP_WR_LOCK: lock_o[region_i] <= 1'b1;
        OP_UNLOCK:           lock_o[region_i] <= 1'b0;
        OP_ERASE_ALL: begin
          lock_o <= '0;
          sec_o  <= 1'b0;
        end
        OP_GP_SET:           gp_o[gp_idx_i] <= 1'b1;
        OP_GP_CLR:           gp_o[gp_idx_i] <= 1'b0;
        OP_SEC_SET:          sec_o <= 1'b1;
        default:             ;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int NUM_REGIONS      = 16,
  parameter int PAGES_PER_REGION = 64,
  parameter int NUM_GP           = 3,
  localparam int PAGE_W          = 10,
  localparam int RGN_W           = $clog2(NUM_REGIONS),
  localparam int GP_W            = (NUM_GP > 1) ? $clog2(NUM_GP) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [3:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              array_wr_o,
  output logic              array_erase_o,
  output logic [PAGE_W-1:0] array_page_o
);
  logic [7:0]             cyc_q;
  logic                   ws_q;
  logic [7:0]             op_q;
  logic [PAGE_W-1:0]      page_q;
  logic [RGN_W-1:0]       rgn_q;
  flags_t                 flg_q;
  logic                   busy, done, start, accept, cmd_wr, stat_rd;
  logic                   legal, lock_err;
  logic [7:0]             dec_op;
  logic [PAGE_W-1:0]      dec_page;
  logic [RGN_W-1:0]       dec_rgn;
  logic [NUM_REGIONS-1:0] lock_q;
  logic [NUM_GP-1:0]      gp_q;
  logic                   sec_q;
  logic [15:0]            lock16;
  logic [7:0]             gp8;
  logic [31:0]            status;

  assign cmd_wr  = reg_we_i && reg_addr_i == OFS_CMD;
  assign stat_rd = reg_re_i && reg_addr_i == OFS_STAT;
  assign accept  = cmd_wr && !busy;
  assign start   = accept && legal && !lock_err;

  flash_cmd_decode #(
    .NUM_REGIONS(NUM_REGIONS), .PAGES_PER_REGION(PAGES_PER_REGION),
    .NUM_GP(NUM_GP), .PAGE_W(PAGE_W)
  ) u_dec (
    .word_i(reg_wdata_i), .lock_i(lock_q), .sec_i(sec_q),
    .legal_o(legal), .lock_err_o(lock_err), .op_o(dec_op),
    .page_o(dec_page), .region_o(dec_rgn)
  );

  flash_cmd_timer #(.CNT_W(8)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .cycles_i(cyc_q),
    .busy_o(busy), .done_o(done)
  );

  flash_cmd_nvstate #(.NUM_REGIONS(NUM_REGIONS), .NUM_GP(NUM_GP)) u_nv (
    .clk_i(clk_i), .rst_ni(rst_ni), .apply_i(done), .op_i(op_q),
    .region_i(rgn_q), .gp_idx_i(page_q[GP_W-1:0]),
    .lock_o(lock_q), .gp_o(gp_q), .sec_o(sec_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= '0;
      ws_q   <= 1'b0;
      op_q   <= '0;
      page_q <= '0;
      rgn_q  <= '0;
    end else begin
      if (reg_we_i && reg_addr_i == OFS_MODE) begin
        cyc_q <= reg_wdata_i[23:16];
        ws_q  <= reg_wdata_i[8];
      end
      if (start) begin
        op_q   <= dec_op;
        page_q <= dec_page;
        rgn_q  <= dec_rgn;
      end
    end
  end

  // sticky flags: a new event wins over a clearing read in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flg_q <= '0;
    end else begin
      if (accept && !legal)                         flg_q.bad_cmd  <= 1'b1;
      else if (stat_rd)                             flg_q.bad_cmd  <= 1'b0;
      if (accept && legal && lock_err)              flg_q.lock_err <= 1'b1;
      else if (stat_rd)                             flg_q.lock_err <= 1'b0;
      if (done && (op_q == OP_LOCK || op_q == OP_UNLOCK)) flg_q.eol <= 1'b1;
      else if (stat_rd)                             flg_q.eol      <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      array_wr_o    <= 1'b0;
      array_erase_o <= 1'b0;
      array_page_o  <= '0;
    end else begin
      array_wr_o    <= done && (op_q == OP_WR_PAGE || op_q == OP_WR_LOCK);
      array_erase_o <= done && op_q == OP_ERASE_ALL;
      if (done) array_page_o <= page_q;
    end
  end

  always_comb begin
    lock16 = '0;
    lock16[NUM_REGIONS-1:0] = lock_q;
    gp8 = '0;
    gp8[NUM_GP-1:0] = gp_q;
  end

  assign status = {lock16, gp8, 3'b000, sec_q, flg_q.bad_cmd, flg_q.lock_err, flg_q.eol, !busy};

  always_comb begin
    case (reg_addr_i)
      OFS_MODE: reg_rdata_o = {8'h00, cyc_q, 7'h00, ws_q, 8'h00};
      OFS_STAT: reg_rdata_o = status;
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk #(
  parameter int NUM_REGIONS = 16
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   done,
  input logic                   stat_rd,
  input logic                   reg_we_i,
  input logic [NUM_REGIONS-1:0] lock_q,
  input logic                   sec_q,
  input logic [2:0]             flags,
  input logic                   array_wr_o,
  input logic                   array_erase_o
);
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({array_wr_o, array_erase_o})); // R8
  AST_WR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    array_wr_o |=> !array_wr_o); // R8
  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done |=> $stable(lock_q)); // R6
  AST_SEC_ONLY_ERASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sec_q) |-> array_erase_o); // R11
  AST_ERASE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    array_erase_o |-> (lock_q == '0 && !sec_q)); // R9
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && !reg_we_i && !done) |=> flags == 3'b000); // R12
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.NUM_REGIONS(NUM_REGIONS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .done(done), .stat_rd(stat_rd),
  .reg_we_i(reg_we_i), .lock_q(lock_q), .sec_q(sec_q), .flags(flg_q),
  .array_wr_o(array_wr_o), .array_erase_o(array_erase_o)
);

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;
  localparam int PPR = 64;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        awr, aer;
  logic [9:0]  apage;

  int nchk = 0, nbad = 0, nwr = 0, ner = 0, cyc = 0;
  logic [9:0]  last_page = '0;
  logic [15:0] e_lock = '0;
  logic [2:0]  e_gp = '0;
  logic        e_sec = 1'b0;
  logic        done_flag = 1'b0;

  flash_cmd_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .array_wr_o(awr), .array_erase_o(aer), .array_page_o(apage)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    if (awr) begin nwr++; last_page = apage; end
    if (aer) ner++;
  end

  initial begin
    while (cyc < 150000) @(negedge clk);
    if (!done_flag) begin
      nbad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s got=%08h exp=%08h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] cw(input logic [7:0] key, input int page, input logic [7:0] code);
    logic [9:0] p;
    p = 10'(page);
    return {key, 6'b0, p, code};
  endfunction

  function automatic logic [31:0] st(input logic bad, input logic lerr, input logic eol);
    return {e_lock, 5'b0, e_gp, 3'b0, e_sec, bad, lerr, eol, 1'b1};
  endfunction

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    re = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic wait_ready(output logic [31:0] s, output int n);
    n = 0;
    for (int i = 0; i < 400; i++) begin
      bus_rd(4'h8, s);
      if (s[0]) break;
      n++;
    end
  endtask

  task automatic cmd(input logic [31:0] w, output logic [31:0] s);
    int n;
    bus_wr(4'h4, w);
    wait_ready(s, n);
  endtask

  initial begin
    logic [31:0] s;
    int n, w0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    bus_rd(4'h8, s); chk("R1 reset status", s, 32'h1);
    bus_rd(4'h0, s); chk("R1 reset mode", s, 32'h0);

    bus_wr(4'h0, 32'hFFFF_FFFF);
    bus_rd(4'h0, s); chk("R13 mode fields", s, 32'h00FF_0100);
    bus_wr(4'h0, 32'h0002_0000);

    cmd(cw(8'hA5, 0, 8'h02), s); chk("R2 bad key", s, st(1, 0, 0));
    bus_rd(4'h8, s); chk("R12 read clears bad", s, st(0, 0, 0));

    for (int c = 0; c < 256; c++) begin
      if (c inside {1, 2, 3, 4, 8, 11, 13, 15}) continue;
      cmd(cw(8'h5A, 0, 8'(c)), s);
      chk($sformatf("R3 unknown code %02h", c), s, st(1, 0, 0));
    end

    for (int f = 0; f <= 21; f++) begin
      int fv;
      fv = (f == 21) ? 255 : f;
      bus_wr(4'h0, {8'h0, 8'(fv), 16'h0});
      bus_wr(4'h4, cw(8'h5A, 0, 8'h0B));
      wait_ready(s, n);
      e_gp[0] = 1'b1;
      chk($sformatf("R4 busy len F=%0d", fv), n, (fv == 0) ? 1 : fv);
    end
    cmd(cw(8'h5A, 0, 8'h0D), s); e_gp[0] = 1'b0;

    bus_wr(4'h0, 32'h000A_0000);
    bus_wr(4'h4, cw(8'h5A, 3 * PPR + 1, 8'h02));
    bus_wr(4'h4, cw(8'h5A, 5 * PPR, 8'h02));
    wait_ready(s, n);
    e_lock[3] = 1'b1;
    chk("R5 write during busy ignored", s, st(0, 0, 1));
    cmd(cw(8'h5A, 3 * PPR, 8'h04), s); e_lock[3] = 1'b0;
    chk("R7 unlock eol", s, st(0, 0, 1));
    bus_wr(4'h0, 32'h0001_0000);

    for (int r = 0; r < 16; r++) begin
      cmd(cw(8'h5A, r * PPR + (r * 13) % PPR, 8'h02), s);
      e_lock[r] = 1'b1;
      chk($sformatf("R6 R7 lock region %0d", r), s, st(0, 0, 1));
      cmd(cw(8'h5A, r * PPR + PPR - 1, 8'h04), s);
      e_lock[r] = 1'b0;
      chk($sformatf("R6 unlock region %0d", r), s, st(0, 0, 1));
    end

    cmd(cw(8'h5A, 2 * PPR, 8'h02), s); e_lock[2] = 1'b1;
    w0 = nwr;
    cmd(cw(8'h5A, 2 * PPR + 5, 8'h01), s);
    chk("R8 write locked region", s, st(0, 1, 0));
    chk("R8 no strobe when locked", nwr, w0);
    cmd(cw(8'h5A, 4 * PPR + 1, 8'h01), s);
    chk("R8 write page status", s, st(0, 0, 0));
    chk("R8 write strobe count", nwr, w0 + 1);
    chk("R8 write strobe page", last_page, 10'(4 * PPR + 1));
    cmd(cw(8'h5A, 6 * PPR + 2, 8'h03), s); e_lock[6] = 1'b1;
    chk("R8 write-then-lock status", s, st(0, 0, 0));
    chk("R8 write-then-lock strobe", nwr, w0 + 2);

    cmd(cw(8'h5A, 0, 8'h08), s);
    chk("R9 erase refused with locks", s, st(0, 1, 0));
    chk("R9 no erase strobe", ner, 0);

    cmd(cw(8'h5A, 0, 8'h0F), s); e_sec = 1'b1;
    chk("R11 security set", s, st(0, 0, 0));
    cmd(cw(8'h5A, 1, 8'h0B), s); e_gp[1] = 1'b1;
    cmd(cw(8'h5A, 2 * PPR, 8'h04), s); e_lock[2] = 1'b0;
    chk("R11 security kept", s, st(0, 0, 1));
    cmd(cw(8'h5A, 0, 8'h08), s); e_lock = '0; e_sec = 1'b0;
    chk("R9 R11 erase clears", s, st(0, 0, 0));
    chk("R9 erase strobe", ner, 1);

    for (int g = 0; g < 3; g++) begin
      cmd(cw(8'h5A, g, 8'h0B), s); e_gp[g] = 1'b1;
      chk($sformatf("R10 gp set %0d", g), s, st(0, 0, 0));
    end
    for (int g = 0; g < 3; g++) begin
      cmd(cw(8'h5A, g, 8'h0D), s); e_gp[g] = 1'b0;
      chk($sformatf("R10 gp clear %0d", g), s, st(0, 0, 0));
    end
    cmd(cw(8'h5A, 3, 8'h0B), s);
    chk("R10 gp index out of range", s, st(1, 0, 0));

    done_flag = 1'b1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule